// File: doc/BRIEF.md
# Guard-Bit Partitioned Packed Adder

This block adds two 64-bit operands as a set of independent integer lanes. Every lane is one or more whole bytes wide. All lanes share a single 72-bit carry-propagate adder. A spare bit sits above every byte of that adder. The value written into each spare bit decides whether a carry continues into the next byte or stops at that boundary.

A 3-bit lane-size code picks the partition. It can be eight byte lanes, four halfword lanes, two word lanes, or one full 64-bit lane. A fifth code takes the partition from a 7-bit join mask, so lanes of uneven size such as 24 bits can be formed. The block returns the packed sum and one carry bit per byte position. A carry bit is set only at the byte that ends a lane.

Operands and controls are sampled on a clock edge. The results are registered, so the latency is one cycle. Reset is synchronous and active high.

Top module: `gadd_packed_add`

## Requirements
- R1: While `rst` is high at a clock edge, `sum_q` and `lane_cy_q` become zero at that edge.
- R2: The results after a clock edge depend only on the operands and controls sampled at that edge, so a new input set can be applied on every cycle.
- R3: With `mode` = 0, each byte i of `sum_q` is (a_i + b_i) mod 256, and `lane_cy_q[i]` is the carry out of that byte addition.
- R4: With `mode` = 1, the lanes are byte pairs {0,1}, {2,3}, {4,5} and {6,7}. Each lane holds a 16-bit sum, and its carry appears in `lane_cy_q` bits 1, 3, 5 and 7.
- R5: With `mode` = 2, the lanes are bytes 0..3 and bytes 4..7. Each lane holds a 32-bit sum, and its carry appears in `lane_cy_q` bits 3 and 7.
- R6: With `mode` = 3, {`lane_cy_q[7]`, `sum_q`} is the full 65-bit sum of the operands.
- R7: With `mode` = 4, `raw_join[j]` = 1 places bytes j and j+1 in the same lane, and `raw_join[j]` = 0 puts a lane boundary between them. This allows lanes of any whole-byte width, such as 24 bits. In every other mode, `raw_join` has no effect on the outputs.
- R8: `lane_cy_q[i]` is zero whenever byte i is not the top byte of its lane.
- R9: The unused codes 5, 6 and 7 of `mode` behave exactly like code 0.
- R10: A carry never crosses a lane boundary. For example, all-ones plus one in every lane gives a zero sum with every lane carry set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| mode | input | 3 | Lane-size code: 0 byte, 1 halfword, 2 word, 3 full, 4 raw mask |
| raw_join | input | 7 | Join mask for code 4; bit j joins byte j and byte j+1 |
| sum_q | output | 64 | Registered packed sum |
| lane_cy_q | output | 8 | Registered carry-out, one bit per byte position |

## Verification
The hardest case to reach is a carry that would cross a killed boundary. Random operands rarely produce a full-length carry chain that ends exactly at a lane edge. The stimulus therefore puts all-ones in one operand and a one in the low byte of each lane in the other, in every mode and in several raw partitions, including 24-bit lanes. This drives a carry through every byte up to the boundary. Random operands with random join masks then cover the other partitions, and random masks applied in fixed modes show that the mask is ignored there.

// File: rtl/simd_gadd_pkg.sv
package simd_gadd_pkg;
  typedef enum logic [2:0] {
    LM_B8  = 3'd0,
    LM_B16 = 3'd1,
    LM_B32 = 3'd2,
    LM_B64 = 3'd3,
    LM_RAW = 3'd4
  } lane_mode_e;
endpackage

// File: rtl/gadd_mask_dec.sv
module gadd_mask_dec #(
  parameter int BYTES = 8
) (
  input  logic [2:0]       mode,
  input  logic [BYTES-2:0] raw_join,
  output logic [BYTES-2:0] join_mask
);
  import simd_gadd_pkg::*;

  logic [BYTES-2:0] m16, m32, m64;

  // boundary j lies between byte j and byte j+1
  for (genvar j = 0; j < BYTES-1; j++) begin : g_fix
    assign m16[j] = ((j + 1) % 2) != 0;
    assign m32[j] = ((j + 1) % 4) != 0;
    assign m64[j] = 1'b1;
  end

  always_comb begin
    case (mode)
      LM_B16:  join_mask = m16;
      LM_B32:  join_mask = m32;
      LM_B64:  join_mask = m64;
      LM_RAW:  join_mask = raw_join;
      default: join_mask = '0;
    endcase
  end
endmodule

// File: rtl/gadd_spread.sv
module gadd_spread #(
  parameter int BYTES = 8,
  parameter int SEG   = 8,
  localparam int W    = BYTES * SEG,
  localparam int IW   = BYTES * (SEG + 1)
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [BYTES-2:0] join_mask,
  output logic [IW-1:0]    wa,
  output logic [IW-1:0]    wb
);
  for (genvar i = 0; i < BYTES; i++) begin : g_slice
    assign wa[i*(SEG+1) +: SEG] = a[i*SEG +: SEG];
    assign wb[i*(SEG+1) +: SEG] = b[i*SEG +: SEG];
    if (i < BYTES-1) begin : g_guard
      // 1/0 passes the carry on, 0/0 absorbs it into the guard position
      assign wa[i*(SEG+1) + SEG] = join_mask[i];
      assign wb[i*(SEG+1) + SEG] = 1'b0;
    end else begin : g_top
      assign wa[i*(SEG+1) + SEG] = 1'b0;
      assign wb[i*(SEG+1) + SEG] = 1'b0;
    end
  end
endmodule

// File: rtl/gadd_gather.sv
module gadd_gather #(
  parameter int BYTES = 8,
  parameter int SEG   = 8,
  localparam int W    = BYTES * SEG,
  localparam int IW   = BYTES * (SEG + 1)
) (
  input  logic [IW-1:0]    wsum,
  input  logic [BYTES-2:0] join_mask,
  output logic [W-1:0]     sum,
  output logic [BYTES-1:0] lane_cy
);
  for (genvar i = 0; i < BYTES; i++) begin : g_slice
    logic lane_top;
    if (i < BYTES-1) begin : g_mid
      assign lane_top = ~join_mask[i];
    end else begin : g_last
      assign lane_top = 1'b1;
    end
    assign sum[i*SEG +: SEG] = wsum[i*(SEG+1) +: SEG];
    assign lane_cy[i]        = lane_top & wsum[i*(SEG+1) + SEG];
  end
endmodule

// File: rtl/gadd_packed_add.sv
module gadd_packed_add #(
  parameter int BYTES = 8,
  parameter int SEG   = 8,
  localparam int W    = BYTES * SEG,
  localparam int IW   = BYTES * (SEG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [2:0]       mode,
  input  logic [BYTES-2:0] raw_join,
  output logic [W-1:0]     sum_q,
  output logic [BYTES-1:0] lane_cy_q
);
  logic [BYTES-2:0] join_mask;
  logic [IW-1:0]    wa, wb, wsum;
  logic [W-1:0]     sum_d;
  logic [BYTES-1:0] cy_d;

  gadd_mask_dec #(.BYTES(BYTES)) u_dec (
    .mode(mode), .raw_join(raw_join), .join_mask(join_mask)
  );

  gadd_spread #(.BYTES(BYTES), .SEG(SEG)) u_spread (
    .a(op_a), .b(op_b), .join_mask(join_mask), .wa(wa), .wb(wb)
  );

  // one wide carry-propagate adder shared by all lanes
  assign wsum = wa + wb;

  gadd_gather #(.BYTES(BYTES), .SEG(SEG)) u_gather (
    .wsum(wsum), .join_mask(join_mask), .sum(sum_d), .lane_cy(cy_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q     <= '0;
      lane_cy_q <= '0;
    end else begin
      sum_q     <= sum_d;
      lane_cy_q <= cy_d;
    end
  end
endmodule

// File: rtl/gadd_packed_add_chk.sv
module gadd_packed_add_chk #(
  parameter int BYTES = 8,
  parameter int SEG   = 8,
  localparam int W    = BYTES * SEG
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     op_a,
  input logic [W-1:0]     op_b,
  input logic [2:0]       mode,
  input logic [BYTES-2:0] raw_join,
  input logic [W-1:0]     sum_q,
  input logic [BYTES-1:0] lane_cy_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && lane_cy_q == '0)); // R1

  AST_FULL_WIDTH_SUM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 3'd3) |->
      ({lane_cy_q[BYTES-1], sum_q} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)}))); // R6

  AST_FULL_NO_INNER_CY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 3'd3) |-> (lane_cy_q[BYTES-2:0] == '0)); // R8

  AST_RAW_ALL_JOIN_ONE_CY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 3'd4 && $past(raw_join) == '1) |->
      ($countones(lane_cy_q[BYTES-2:0]) == 0)); // R7

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    AST_BYTE_LANE_SUM: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(mode) == 3'd0) |->
        ({lane_cy_q[i], sum_q[i*SEG +: SEG]} ==
         ({1'b0, $past(op_a[i*SEG +: SEG])} + {1'b0, $past(op_b[i*SEG +: SEG])}))); // R3
  end
endmodule

bind gadd_packed_add gadd_packed_add_chk #(.BYTES(BYTES), .SEG(SEG)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .mode(mode),
  .raw_join(raw_join), .sum_q(sum_q), .lane_cy_q(lane_cy_q)
);

// File: tb/sim_gadd_packed_add.sv
module sim_gadd_packed_add;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_a = '0, op_b = '0;
  logic [2:0]  mode = '0;
  logic [6:0]  raw_join = '0;
  logic [63:0] sum_q;
  logic [7:0]  lane_cy_q;
  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gadd_packed_add u0 (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .mode(mode),
    .raw_join(raw_join), .sum_q(sum_q), .lane_cy_q(lane_cy_q)
  );

  function automatic logic [6:0] mask_of(input logic [2:0] md, input logic [6:0] raw);
    case (md)
      3'd1:    return 7'b1010101;
      3'd2:    return 7'b1110111;
      3'd3:    return 7'b1111111;
      3'd4:    return raw;
      default: return 7'b0000000;
    endcase
  endfunction

  // behavioural lane-by-lane reference
  task automatic ref_add(input logic [63:0] a, input logic [63:0] b,
                         input logic [2:0] md, input logic [6:0] raw,
                         output logic [63:0] s, output logic [7:0] cy);
    logic [6:0] m;
    int c;
    m = mask_of(md, raw);
    c = 0;
    s = '0;
    cy = '0;
    for (int i = 0; i < 8; i++) begin
      int t;
      t = int'(a[8*i +: 8]) + int'(b[8*i +: 8]) + c;
      s[8*i +: 8] = t[7:0];
      if (i < 7 && m[i]) c = t >> 8;
      else begin
        cy[i] = t[8];
        c = 0;
      end
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic [2:0] md, input logic [6:0] raw, input string tag);
    logic [63:0] es;
    logic [7:0]  ec;
    ref_add(a, b, md, raw, es, ec);
    op_a = a; op_b = b; mode = md; raw_join = raw;
    @(negedge clk);
    n_vec++;
    if (sum_q !== es || lane_cy_q !== ec) begin
      n_bad++;
      $display("FAIL %s mode=%0d raw=%b: got sum=%h cy=%b, expected sum=%h cy=%b",
               tag, md, raw, sum_q, lane_cy_q, es, ec);
    end
  endtask

  function automatic logic [63:0] lane_ones(input logic [6:0] m);
    logic [63:0] v = '0;
    v[0] = 1'b1;
    for (int j = 0; j < 7; j++) if (!m[j]) v[8*(j+1)] = 1'b1;
    return v;
  endfunction

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (sum_q !== '0 || lane_cy_q !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: got sum=%h cy=%b, expected 0 and 0", sum_q, lane_cy_q);
    end
    rst = 1'b0;

    // R10 all-ones plus one per lane, every fixed mode (R3 R4 R5 R6)
    for (int md = 0; md < 4; md++)
      apply('1, lane_ones(mask_of(3'(md), 7'd0)), 3'(md), 7'h55, "R10");
    // R7 24-bit lanes {0..2},{3..5},{6,7}
    apply('1, lane_ones(7'b1011011), 3'd4, 7'b1011011, "R7");
    apply(64'h00FF_FFFF_00FF_FFFF, 64'h0000_0001_0000_0001, 3'd4, 7'b1011011, "R7");
    apply('1, '1, 3'd4, 7'b0000000, "R8");
    apply('1, 64'd1, 3'd3, 7'd0, "R6");

    // R2 back-to-back random vectors in every mode
    for (int md = 0; md < 8; md++)
      for (int k = 0; k < 300; k++) begin
        string tg;
        case (md)
          0: tg = "R3"; 1: tg = "R4"; 2: tg = "R5"; 3: tg = "R6";
          4: tg = "R7"; default: tg = "R9";
        endcase
        apply({$urandom, $urandom}, {$urandom, $urandom}, 3'(md), 7'($urandom), tg);
      end

    // R9 unused codes with all-ones corner
    for (int md = 5; md < 8; md++) apply('1, 64'h0101_0101_0101_0101, 3'(md), 7'h7F, "R9");

    // R8 random masks with long carry chains
    for (int k = 0; k < 200; k++) begin
      logic [6:0] m = 7'($urandom);
      apply('1, lane_ones(m), 3'd4, m, "R8");
    end

    // R1 reset during operation
    op_a = '1; op_b = '1; mode = 3'd3;
    rst = 1'b1;
    @(negedge clk);
    n_vec++;
    if (sum_q !== '0 || lane_cy_q !== '0) begin
      n_bad++;
      $display("FAIL R1 mid reset: got sum=%h cy=%b, expected 0 and 0", sum_q, lane_cy_q);
    end
    rst = 1'b0;
    apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 3'd3, 7'd0, "R6");

    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end
endmodule